// File: doc/BRIEF.md
# Chirp and FSK Tuning-Word Generator

This block produces the 48-bit frequency tuning word that feeds a phase accumulator. It has four operating modes. The first emits a single fixed word. The second is plain two-word FSK, where one control pin picks the word. The third is ramped FSK, which steps from the current frequency towards the selected word in equal increments and stops exactly on it. The fourth is a linear chirp, which adds a signed increment at a programmed interval.

A programmable interval timer sets how often the internal frequency accumulator moves. The shared control pin has two roles. In FSK and ramped-FSK modes it selects the target word. In chirp mode it freezes the sweep: the accumulator and the timer both stop while the pin is high. A one-cycle update strobe loads the accumulator with a start word and restarts the timer. The chosen word then passes through a fixed pipeline before it reaches the output, so that its latency matches the rest of the synthesis path.

Top module: `chirp_ftw_gen`

## Requirements
- R1: While reset is asserted, and until the first value captured after reset reaches the end of the pipeline, `ftw_out` is zero.
- R2: With `mode` = 0 (single tone), the word sent to the pipeline is `word_a`, whatever the level of `pin`.
- R3: With `mode` = 1 (FSK), the word sent to the pipeline is `word_a` when `pin` is 0 and `word_b` when `pin` is 1.
- R4: With `mode` = 3 (chirp) and `pin` low, the accumulator adds the two's-complement `delta` modulo 2^48 once every `rate`+1 cycles. Between additions the timer counts down from `rate` to 0, and it reloads `rate` on each addition.
- R5: With `mode` = 3 and `pin` high, the accumulator and the timer both keep their values. When `pin` falls, the countdown resumes from the held count.
- R6: An `upd` pulse loads the accumulator with `start_word` and the timer with `rate` on the next edge. It takes priority over every mode.
- R7: With `mode` = 2 (ramped FSK), each time the timer reaches 0 the accumulator moves towards the target (`word_a` when `pin` is 0, `word_b` when `pin` is 1) by the magnitude of `delta`. A step that would pass the target lands exactly on the target, and the accumulator then stays there. The timer reloads `rate` on each such step.
- R8: The value selected at a clock edge appears on `ftw_out` exactly `OUT_LAT` edges later. The default `OUT_LAT` is 26. In modes 2 and 3 the selected value is the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Mode: 0 single, 1 FSK, 2 ramped FSK, 3 chirp |
| pin | input | 1 | FSK select or chirp hold |
| upd | input | 1 | Load strobe for start word and timer |
| delta | input | FW | Signed step word |
| rate | input | RW | Timer reload value; the interval is rate+1 cycles |
| start_word | input | FW | Value loaded into the accumulator on `upd` |
| word_a | input | FW | First tuning word |
| word_b | input | FW | Second tuning word |
| ftw_out | output | FW | Pipelined tuning word |

## Verification
The ramp properties take for granted that `word_a`, `word_b` and `delta` stay constant over any cycle in which the accumulator is moving in mode 2. The stimulus changes these inputs only at the start of a phase. Within a phase it toggles only `pin` and `upd`.

The chirp step property allows the sum to wrap modulo 2^48. A directed case drives a negative step through zero to exercise that wrap. The bench keeps `OUT_LAT` below 64, because its record of expected outputs has 64 entries.

// File: rtl/chirp_ftw_gen.sv
module chirp_ftw_gen #(
  parameter int FW = 48,
  parameter int RW = 16,
  parameter int OUT_LAT = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          pin,
  input  logic          upd,
  input  logic [FW-1:0] delta,
  input  logic [RW-1:0] rate,
  input  logic [FW-1:0] start_word,
  input  logic [FW-1:0] word_a,
  input  logic [FW-1:0] word_b,
  output logic [FW-1:0] ftw_out
);
  localparam logic [1:0] M_SINGLE = 2'd0;
  localparam logic [1:0] M_FSK    = 2'd1;
  localparam logic [1:0] M_RAMP   = 2'd2;
  localparam logic [1:0] M_CHIRP  = 2'd3;

  logic [FW-1:0] acc_q, tgt, mag, gap, ramp_nx, src;
  logic [RW-1:0] cnt_q;
  logic          tick, up;
  logic [FW-1:0] pipe [OUT_LAT];

  assign tgt     = pin ? word_b : word_a;
  assign tick    = (cnt_q == '0);
  assign mag     = delta[FW-1] ? (~delta + 1'b1) : delta;
  assign up      = acc_q < tgt;
  assign gap     = up ? (tgt - acc_q) : (acc_q - tgt);
  assign ramp_nx = (gap <= mag) ? tgt : (up ? acc_q + mag : acc_q - mag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      acc_q <= start_word;
      cnt_q <= rate;
    end else begin
      case (mode)
        M_CHIRP: begin
          if (!pin) begin
            if (tick) begin
              acc_q <= acc_q + delta;
              cnt_q <= rate;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        M_RAMP: begin
          if (tick) begin
            acc_q <= ramp_nx;
            cnt_q <= rate;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: cnt_q <= rate;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_SINGLE: src = word_a;
      M_FSK:    src = tgt;
      default:  src = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OUT_LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= src;
      for (int i = 1; i < OUT_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign ftw_out = pipe[OUT_LAT-1];
endmodule

// File: rtl/chirp_ftw_gen_chk.sv
module chirp_ftw_gen_chk #(
  parameter int FW = 48,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          pin,
  input logic          upd,
  input logic [FW-1:0] delta,
  input logic [FW-1:0] start_word,
  input logic [FW-1:0] acc,
  input logic [RW-1:0] cnt,
  input logic [FW-1:0] tgt
);
  AST_UPD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> acc == $past(start_word)); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && pin && !upd) |=> ($stable(acc) && $stable(cnt))); // R5
  AST_CHIRP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !pin && !upd && cnt == '0) |=> acc == $past(acc) + $past(delta)); // R4
  AST_TIMER_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !pin && !upd && cnt != '0) |=> (cnt == $past(cnt) - 1'b1 && $stable(acc))); // R4
  AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !upd && acc <= tgt) |=> acc <= $past(tgt)); // R7
  AST_RAMP_NO_UNDERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !upd && acc >= tgt) |=> acc >= $past(tgt)); // R7
endmodule

bind chirp_ftw_gen chirp_ftw_gen_chk #(.FW(FW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .pin(pin), .upd(upd), .delta(delta),
  .start_word(start_word), .acc(acc_q), .cnt(cnt_q), .tgt(tgt)
);

// File: tb/chirp_ftw_gen_tb.sv
module chirp_ftw_gen_tb_top;
  localparam int FW = 48;
  localparam int RW = 16;
  localparam int L  = 26;

  logic clk = 0, rst_n = 0, pin = 0, upd = 0;
  logic [1:0] mode = 0;
  logic [FW-1:0] delta = 0, start_word = 0, word_a = 0, word_b = 0;
  logic [RW-1:0] rate = 0;
  logic [FW-1:0] ftw_out;

  int checks = 0, fails = 0;
  logic [FW-1:0] macc = 0;
  logic [RW-1:0] mcnt = 0;
  logic [FW-1:0] hq [64];
  string hs [64];
  int n = 64;

  always #2.5 clk = ~clk;

  chirp_ftw_gen #(.FW(FW), .RW(RW), .OUT_LAT(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pin(pin), .upd(upd), .delta(delta),
    .rate(rate), .start_word(start_word), .word_a(word_a), .word_b(word_b),
    .ftw_out(ftw_out));

  function automatic logic [FW-1:0] ramp_step(logic [FW-1:0] cur, logic [FW-1:0] t,
                                               logic [FW-1:0] d);
    logic [FW-1:0] m = d[FW-1] ? -d : d;
    if (cur < t) return (t - cur <= m) ? t : cur + m;
    return (cur - t <= m) ? t : cur - m;
  endfunction

  task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic [FW-1:0] t;
    string tag;
    @(posedge clk);
    t = pin ? word_b : word_a;
    n++;
    case (mode)
      2'd0: begin hq[n%64] = word_a; tag = "R2"; end
      2'd1: begin hq[n%64] = t;      tag = "R3"; end
      2'd2: begin hq[n%64] = macc;   tag = "R7"; end
      default: begin hq[n%64] = macc; tag = pin ? "R5" : "R4"; end
    endcase
    if (upd) begin
      macc = start_word; mcnt = rate; tag = "R6";
    end else if (mode == 2'd3) begin
      if (!pin) begin
        if (mcnt == 0) begin macc = macc + delta; mcnt = rate; end
        else mcnt = mcnt - 1'b1;
      end
    end else if (mode == 2'd2) begin
      if (mcnt == 0) begin macc = ramp_step(macc, t, delta); mcnt = rate; end
      else mcnt = mcnt - 1'b1;
    end else mcnt = rate;
    hs[n%64] = tag;
    @(negedge clk);
    check(hs[(n-L+1)%64], ftw_out, hq[(n-L+1)%64]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int first;
    logic [FW-1:0] base;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 64; i++) begin hq[i] = '0; hs[i] = "R1"; end
    repeat (3) @(negedge clk);
    check("R1", ftw_out, '0);
    rst_n = 1;

    // R8: measured latency from a fresh pipeline
    mode = 0; word_a = 48'h1234_5678_9abc; first = 0;
    for (int k = 1; k <= L + 4; k++) begin
      cyc();
      if (first == 0 && ftw_out == word_a) first = k;
    end
    checks++;
    if (first != L) begin
      fails++;
      $display("FAIL R8 actual=%0d expected=%0d", first, L);
    end

    // R4/R6: negative chirp through zero
    mode = 3; rate = 0; delta = -48'sd3; start_word = 48'h1; upd = 1; cyc(); upd = 0;
    repeat (L + 8) cyc();

    // R7: last step clamped onto the target
    mode = 2; rate = 1; word_a = 100; word_b = 110; delta = 4; pin = 1;
    start_word = 100; upd = 1; cyc(); upd = 0;
    repeat (L + 12) cyc();

    // R5: hold in mid-count, then resume
    mode = 3; rate = 5; delta = 7; pin = 0; start_word = 0; upd = 1; cyc(); upd = 0;
    repeat (3) cyc(); pin = 1; repeat (10) cyc(); pin = 0;
    repeat (L + 10) cyc();

    for (int p = 0; p < 40; p++) begin
      mode = 2'($urandom % 4);
      rate = RW'($urandom % 4);
      base = {$urandom, $urandom};
      word_a = base;
      word_b = base + FW'($urandom % 2000);
      if (mode == 2'd3) delta = {$urandom, $urandom};
      else begin
        delta = FW'(1 + $urandom % 300);
        if ($urandom % 2) delta = -delta;
      end
      start_word = base + FW'($urandom % 2000);
      upd = 1; cyc(); upd = 0;
      for (int c = 0; c < 100; c++) begin
        if ($urandom % 16 == 0) pin = ~pin;
        upd = ($urandom % 64 == 0);
        cyc();
      end
      upd = 0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule